// File: doc/BRIEF.md
# Three-Wire Command and Status Serial Port

This block is the slave end of a three-line host link: a serial clock, a load line and one data line that the block drives only while it returns data. The host uses it to write an 8-bit command word and to read back an 8-bit status word. All three lines are asynchronous to the system clock. Each line passes through its own synchroniser, and an edge detector turns the synchronised clock line into one-cycle strobes.

The level of the load line when a transfer starts selects the direction. With the load line HIGH, the clock pulses shift in a command byte, MSB first, and the load line falling commits that byte. With the load line LOW, the block snapshots the status word and presents its bits MSB first, moving to the next bit at each rising clock edge. The host ends every transfer by returning both lines HIGH. Two command bits are one-shot strobes that clear themselves one cycle after they are written. Three status bits record events, and a completed read clears them. An event that arrives while a read is in progress is kept for the next read.

Top module: `cspPort`

## Requirements
- R1: After reset the command output is 0x40, with only the bypass bit (bit 6) set. The three event bits of the status word are clear, and the data line is not driven.
- R2: A write is made of at least eight rising serial-clock edges with the load line HIGH, and then a falling load line. The last eight bits sampled, MSB first, become the command word. Outside such a commit, the command bits other than the one-shot bits never change.
- R3: A write in which fewer than eight rising clock edges come before the load line falls leaves the command word unchanged.
- R4: Command bit 7 (flush) and bit 0 (position found) each read HIGH for exactly one system-clock cycle after a commit that sets them, and then read LOW. The other written bits persist.
- R5: In a read, the status word is captured when the load line falls. Bit 7 appears first on serDataOut, and each rising serial-clock edge moves to the next lower bit. serDataOe is HIGH only while a read is in progress.
- R6: Status bits 5 (frame error), 4 (new frame) and 3 (full) are set by one-cycle pulses on their inputs. They stay set until a read with eight rising clock edges completes, and are clear after it. A read with fewer edges clears nothing.
- R7: An event pulse that arrives during a read is not lost. It stays set for the next read, even when the same bit was already set and was shown by the current read.
- R8: Status bits 7:6 (FIFO length MSBs), 2 (empty), 1 (shock) and 0 (fill) show the levels of their inputs at the moment the read is captured.
- R9: The data line is not driven while idle or during a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial clock line from host, idle HIGH |
| serLoad | input | 1 | Load line from host, selects direction, idle HIGH |
| serDataIn | input | 1 | Data line as received by the block |
| serDataOut | output | 1 | Data line value driven during a read |
| serDataOe | output | 1 | Drive enable for the data line, HIGH only in a read |
| fifoLenMsb | input | 2 | FIFO fill-level MSBs reported in status bits 7:6 |
| setFrameErr | input | 1 | One-cycle pulse that sets status bit 5 |
| setNewFrame | input | 1 | One-cycle pulse that sets status bit 4 |
| setFull | input | 1 | One-cycle pulse that sets status bit 3 |
| fifoEmpty | input | 1 | Level reported in status bit 2 |
| shockActive | input | 1 | Level reported in status bit 1 |
| fillActive | input | 1 | Level reported in status bit 0 |
| cmdOut | output | 8 | Command word: 7 flush, 6 bypass, 5 echo, 4 jump busy, 3 track polarity, 2 rotation detect enable, 1 host shock, 0 position found |

## Verification
The assertions assume that the host keeps each serial line level for several system clocks and moves the data line only while the clock is LOW. Under that assumption, the synchronised clock and data lines have the same delay, and no edge is lost. They also assume that a write always begins with a clock fall while the load line is HIGH, and that a read never sees the load line rise while the clock is LOW. The directed stimulus holds every line for six system clocks per half period. It changes data together with the falling clock edge and ends each transfer with the clock already HIGH. It drives event pulses only at falling system-clock edges.

// File: rtl/cspPkg.sv
package cspPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_DONE  = 2'd2,
    ST_READ  = 2'd3
  } cspState_e;

  typedef struct packed {
    logic loadStatus;
    logic shiftIn;
    logic shiftOut;
    logic latchCmd;
    logic clearSticky;
  } cspStrobe_t;

  // command bit positions
  localparam int CMD_FLUSH   = 7;
  localparam int CMD_BYPASS  = 6;
  localparam int CMD_FOUND   = 0;

  // status bit positions
  localparam int ST_LEN_HI   = 7;
  localparam int ST_LEN_LO   = 6;
  localparam int ST_FRMERR   = 5;
  localparam int ST_NEWFRM   = 4;
  localparam int ST_FULL     = 3;
  localparam int ST_EMPTY    = 2;
  localparam int ST_SHOCK    = 1;
  localparam int ST_FILL     = 0;

endpackage

// File: rtl/cspSync.sv
module cspSync #(
  parameter int LINES = 3,
  parameter int STAGES = 2,
  parameter logic [LINES-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] lineIn,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        chain <= {STAGES{RST_VAL[g]}};
        prev  <= RST_VAL[g];
      end else begin
        chain <= {chain[STAGES-2:0], lineIn[g]};
        prev  <= chain[STAGES-1];
      end
    end

    assign level[g] = chain[STAGES-1];
    assign rise[g]  = chain[STAGES-1] & ~prev;
    assign fall[g]  = ~chain[STAGES-1] & prev;
  end

endmodule

// File: rtl/cspCtrl.sv
module cspCtrl
  import cspPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkLvl,
  input  logic       loadLvl,
  input  logic       clkRise,
  input  logic       clkFall,
  output cspStrobe_t strobe,
  output logic       dataOe,
  output cspState_e  stateOut
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  cspState_e        state, nextState;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic             cntFull;

  assign cntFull = (bitCnt == CNT_FULL);

  always_comb begin
    strobe     = '0;
    nextState  = state;
    bitCntNext = bitCnt;
    unique case (state)
      ST_IDLE: begin
        if (!loadLvl) begin
          strobe.loadStatus = 1'b1;
          nextState         = ST_READ;
          bitCntNext        = '0;
        end else if (clkFall) begin
          nextState  = ST_WRITE;
          bitCntNext = '0;
        end
      end
      ST_WRITE: begin
        if (!loadLvl) begin
          strobe.latchCmd = cntFull;
          nextState       = ST_DONE;
        end else if (clkRise) begin
          strobe.shiftIn = 1'b1;
          if (!cntFull) bitCntNext = bitCnt + 1'b1;
        end
      end
      ST_DONE: begin
        if (clkLvl && loadLvl) nextState = ST_IDLE;
      end
      ST_READ: begin
        if (clkLvl && loadLvl) begin
          strobe.clearSticky = cntFull;
          nextState          = ST_IDLE;
        end else if (clkRise) begin
          strobe.shiftOut = 1'b1;
          if (!cntFull) bitCntNext = bitCnt + 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= nextState;
      bitCnt <= bitCntNext;
    end
  end

  assign dataOe   = (state == ST_READ);
  assign stateOut = state;

endmodule

// File: rtl/cspData.sv
module cspData
  import cspPkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_RESET = 8'h40,
  parameter logic [DATA_W-1:0] SELF_CLR_MASK = 8'h81,
  parameter logic [DATA_W-1:0] STICKY_MASK = 8'h38
) (
  input  logic              clk,
  input  logic              rstN,
  input  cspStrobe_t        strobe,
  input  logic              dataBit,
  input  logic [DATA_W-1:0] liveVec,
  input  logic [DATA_W-1:0] setVec,
  output logic [DATA_W-1:0] cmdOut,
  output logic [DATA_W-1:0] stickyOut,
  output logic              shiftMsb
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] cmdReg;
  logic [DATA_W-1:0] stickyReg;
  logic [DATA_W-1:0] snapReg;
  logic [DATA_W-1:0] seenReg;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] setMasked;
  logic [DATA_W-1:0] clrMask;

  assign setMasked  = setVec & STICKY_MASK;
  assign statusWord = (stickyReg & STICKY_MASK) | (liveVec & ~STICKY_MASK);
  // bits shown by this read and not re-raised since are the only ones cleared
  assign clrMask    = strobe.clearSticky ? (snapReg & ~(seenReg | setMasked)) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.loadStatus) begin
      shiftReg <= statusWord;
    end else if (strobe.shiftIn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], dataBit};
    end else if (strobe.shiftOut) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= CMD_RESET;
    end else if (strobe.latchCmd) begin
      cmdReg <= shiftReg;
    end else begin
      cmdReg <= cmdReg & ~SELF_CLR_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyReg <= '0;
      snapReg   <= '0;
      seenReg   <= '0;
    end else begin
      stickyReg <= (stickyReg & ~clrMask) | setMasked;
      if (strobe.loadStatus) begin
        snapReg <= stickyReg & STICKY_MASK;
        seenReg <= setMasked;
      end else begin
        seenReg <= seenReg | setMasked;
      end
    end
  end

  assign cmdOut    = cmdReg;
  assign stickyOut = stickyReg;
  assign shiftMsb  = shiftReg[DATA_W-1];

endmodule

// File: rtl/cspPort.sv
module cspPort
  import cspPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CMD_RESET = 8'h40,
  parameter logic [DATA_W-1:0] SELF_CLR_MASK = 8'h81,
  parameter logic [DATA_W-1:0] STICKY_MASK = 8'h38
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serLoad,
  input  logic              serDataIn,
  output logic              serDataOut,
  output logic              serDataOe,
  input  logic [1:0]        fifoLenMsb,
  input  logic              setFrameErr,
  input  logic              setNewFrame,
  input  logic              setFull,
  input  logic              fifoEmpty,
  input  logic              shockActive,
  input  logic              fillActive,
  output logic [DATA_W-1:0] cmdOut
);

  localparam int LINES = 3;
  localparam int L_CLK = 0;
  localparam int L_LOAD = 1;
  localparam int L_DATA = 2;
  localparam logic [LINES-1:0] LINE_IDLE = 3'b011;

  logic [LINES-1:0]  lineLvl, lineRise, lineFall;
  logic              clkLvl, loadLvl;
  cspStrobe_t        strobe;
  cspState_e         ctrlState;
  logic              dataOe;
  logic              shiftMsb;
  logic [DATA_W-1:0] liveVec, setVec, stickyReg;

  cspSync #(
    .LINES  (LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINE_IDLE)
  ) uSync (
    .clk   (clk),
    .rstN  (rstN),
    .lineIn({serDataIn, serLoad, serClk}),
    .level (lineLvl),
    .rise  (lineRise),
    .fall  (lineFall)
  );

  assign clkLvl  = lineLvl[L_CLK];
  assign loadLvl = lineLvl[L_LOAD];

  always_comb begin
    liveVec = '0;
    liveVec[ST_LEN_HI] = fifoLenMsb[1];
    liveVec[ST_LEN_LO] = fifoLenMsb[0];
    liveVec[ST_EMPTY]  = fifoEmpty;
    liveVec[ST_SHOCK]  = shockActive;
    liveVec[ST_FILL]   = fillActive;
    setVec = '0;
    setVec[ST_FRMERR]  = setFrameErr;
    setVec[ST_NEWFRM]  = setNewFrame;
    setVec[ST_FULL]    = setFull;
  end

  cspCtrl #(
    .DATA_W(DATA_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkLvl  (clkLvl),
    .loadLvl (loadLvl),
    .clkRise (lineRise[L_CLK]),
    .clkFall (lineFall[L_CLK]),
    .strobe  (strobe),
    .dataOe  (dataOe),
    .stateOut(ctrlState)
  );

  cspData #(
    .DATA_W       (DATA_W),
    .CMD_RESET    (CMD_RESET),
    .SELF_CLR_MASK(SELF_CLR_MASK),
    .STICKY_MASK  (STICKY_MASK)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataBit  (lineLvl[L_DATA]),
    .liveVec  (liveVec),
    .setVec   (setVec),
    .cmdOut   (cmdOut),
    .stickyOut(stickyReg),
    .shiftMsb (shiftMsb)
  );

  assign serDataOe  = dataOe;
  assign serDataOut = dataOe & shiftMsb;

endmodule

// File: rtl/cspPortChk.sv
module cspPortChk
  import cspPkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] SELF_CLR_MASK = 8'h81
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] cmdOut,
  input logic              serDataOe,
  input logic              loadLvl,
  input cspStrobe_t        strobe,
  input logic [DATA_W-1:0] stickyReg
);

  p_flush_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut[CMD_FLUSH] |=> !cmdOut[CMD_FLUSH]);

  p_found_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut[CMD_FOUND] |=> !cmdOut[CMD_FOUND]);

  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchCmd |=> ((cmdOut & ~SELF_CLR_MASK) == $past(cmdOut & ~SELF_CLR_MASK)));

  p_drive_on_load_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serDataOe) |-> !$past(loadLvl));

  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearSticky |=> ((stickyReg & $past(stickyReg)) == $past(stickyReg)));

endmodule

bind cspPort cspPortChk #(
  .DATA_W       (DATA_W),
  .SELF_CLR_MASK(SELF_CLR_MASK)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdOut   (cmdOut),
  .serDataOe(serDataOe),
  .loadLvl  (loadLvl),
  .strobe   (strobe),
  .stickyReg(stickyReg)
);

// File: tb/cspPort_test.sv
module cspPort_test;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serClk = 1'b1, serLoad = 1'b1, serDataIn = 1'b0;
  logic       serDataOut, serDataOe;
  logic [1:0] fifoLenMsb = 2'b00;
  logic       setFrameErr = 1'b0, setNewFrame = 1'b0, setFull = 1'b0;
  logic       fifoEmpty = 1'b0, shockActive = 1'b0, fillActive = 1'b0;
  logic [7:0] cmdOut;

  int checks = 0, fails = 0;
  int flushCycles = 0, foundCycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cspPort uut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLoad(serLoad),
    .serDataIn(serDataIn), .serDataOut(serDataOut), .serDataOe(serDataOe),
    .fifoLenMsb(fifoLenMsb), .setFrameErr(setFrameErr), .setNewFrame(setNewFrame),
    .setFull(setFull), .fifoEmpty(fifoEmpty), .shockActive(shockActive),
    .fillActive(fillActive), .cmdOut(cmdOut)
  );

  always @(posedge clk) begin
    if (cmdOut[7]) flushCycles++;
    if (cmdOut[0]) foundCycles++;
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulseEvt(input logic [2:0] evt);
    {setFrameErr, setNewFrame, setFull} = evt;
    @(negedge clk);
    {setFrameErr, setNewFrame, setFull} = 3'b000;
  endtask

  task automatic writeCmd(input logic [7:0] val, input int nBits, output bit oeSeen);
    oeSeen = 0;
    for (int i = 0; i < nBits; i++) begin
      serClk = 1'b0;
      serDataIn = val[7-i];
      for (int k = 0; k < HALF; k++) begin @(negedge clk); oeSeen |= serDataOe; end
      serClk = 1'b1;
      for (int k = 0; k < HALF; k++) begin @(negedge clk); oeSeen |= serDataOe; end
    end
    serLoad = 1'b0;
    for (int k = 0; k < HALF; k++) begin @(negedge clk); oeSeen |= serDataOe; end
    serLoad = 1'b1;
    waitCyc(HALF);
  endtask

  task automatic readStatus(input int nEdges, input logic [2:0] midEvt,
                            output logic [7:0] val, output bit oeAll);
    val = '0;
    oeAll = 1;
    serLoad = 1'b0;
    waitCyc(HALF);
    for (int i = 0; i < nEdges; i++) begin
      val[7-i] = serDataOut;
      oeAll &= serDataOe;
      if (i == 3 && midEvt != 3'b000) pulseEvt(midEvt);
      serClk = 1'b0;
      waitCyc(HALF);
      serClk = 1'b1;
      waitCyc(HALF);
    end
    serLoad = 1'b1;
    waitCyc(HALF);
  endtask

  task automatic tReset();
    logic [7:0] s; bit oe;
    check(cmdOut == 8'h40, "R1 reset command", cmdOut, 8'h40);
    check(serDataOe == 1'b0, "R9 idle not driven", serDataOe, 0);
    readStatus(8, 3'b000, s, oe);
    check(s == 8'h00, "R1 status after reset", s, 8'h00);
    check(oe == 1'b1, "R5 drive during read", oe, 1);
    check(serDataOe == 1'b0, "R5 release after read", serDataOe, 0);
  endtask

  task automatic tWrite();
    bit oe;
    writeCmd(8'h6C, 8, oe);
    check(cmdOut == 8'h6C, "R2 write 0x6C", cmdOut, 8'h6C);
    check(oe == 1'b0, "R9 no drive in write", oe, 0);
    writeCmd(8'h3A, 8, oe);
    check(cmdOut == 8'h3A, "R2 write 0x3A", cmdOut, 8'h3A);
  endtask

  task automatic tShortWrite();
    bit oe;
    writeCmd(8'hC5, 5, oe);
    check(cmdOut == 8'h3A, "R3 short write ignored", cmdOut, 8'h3A);
    writeCmd(8'h00, 7, oe);
    check(cmdOut == 8'h3A, "R3 seven bits ignored", cmdOut, 8'h3A);
  endtask

  task automatic tSelfClear();
    bit oe;
    int f0, p0;
    f0 = flushCycles; p0 = foundCycles;
    writeCmd(8'h15, 8, oe);
    check(cmdOut == 8'h14, "R4 found bit cleared, rest kept", cmdOut, 8'h14);
    check(foundCycles - p0 == 1, "R4 found one cycle", foundCycles - p0, 1);
    check(flushCycles - f0 == 0, "R4 no flush", flushCycles - f0, 0);
    f0 = flushCycles; p0 = foundCycles;
    writeCmd(8'h81, 8, oe);
    check(cmdOut == 8'h00, "R4 both one-shots cleared", cmdOut, 8'h00);
    check(flushCycles - f0 == 1, "R4 flush one cycle", flushCycles - f0, 1);
    check(foundCycles - p0 == 1, "R4 found one cycle again", foundCycles - p0, 1);
  endtask

  task automatic tLive();
    logic [7:0] s; bit oe;
    fifoLenMsb = 2'b10; fifoEmpty = 1; shockActive = 0; fillActive = 1;
    readStatus(8, 3'b000, s, oe);
    check(s == 8'h85, "R8 live bits pattern A", s, 8'h85);
    fifoLenMsb = 2'b01; fifoEmpty = 0; shockActive = 1; fillActive = 0;
    readStatus(8, 3'b000, s, oe);
    check(s == 8'h42, "R8 live bits pattern B", s, 8'h42);
    fifoLenMsb = 2'b00; shockActive = 0;
  endtask

  task automatic tSticky();
    logic [7:0] s; bit oe;
    pulseEvt(3'b101);
    waitCyc(2);
    readStatus(8, 3'b000, s, oe);
    check(s == 8'h28, "R6 frame error and full set", s, 8'h28);
    readStatus(8, 3'b000, s, oe);
    check(s == 8'h00, "R6 cleared by read", s, 8'h00);
    pulseEvt(3'b010);
    readStatus(4, 3'b000, s, oe);
    readStatus(8, 3'b000, s, oe);
    check(s == 8'h10, "R6 partial read keeps bit", s, 8'h10);
    readStatus(8, 3'b000, s, oe);
    check(s == 8'h00, "R6 full read clears bit", s, 8'h00);
  endtask

  task automatic tDuringRead();
    logic [7:0] s; bit oe;
    pulseEvt(3'b010);
    readStatus(8, 3'b010, s, oe);
    check(s == 8'h10, "R7 first read shows new frame", s, 8'h10);
    readStatus(8, 3'b100, s, oe);
    check(s == 8'h10, "R7 re-raised bit kept", s, 8'h10);
    readStatus(8, 3'b000, s, oe);
    check(s == 8'h20, "R7 mid-read event kept", s, 8'h20);
    readStatus(8, 3'b000, s, oe);
    check(s == 8'h00, "R7 all drained", s, 8'h00);
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    tReset();
    tWrite();
    tShortWrite();
    tSelfClear();
    tLive();
    tSticky();
    tDuringRead();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule